// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is a synthesizable model of a single-clock pipelined static RAM. It accepts a new read, write or deselect on every enabled rising edge. No idle cycles are needed when the bus switches between reading and writing. Write data follows its address by two enabled cycles, which is the "late write" scheme. Read data appears in a registered output two enabled cycles after its address. This matching latency lets reads and writes interleave freely on a shared data bus.

A host starts an access by holding the load/continue strobe low with the three chip enables in the selecting pattern. It may then hold the strobe high to step through a short burst. The burst keeps the operation type and advances the low address bits. A clock-enable input freezes the whole pipeline, including the array and the output register. The bidirectional data bus is modelled as separate write-data, read-data and read-valid ports. The read-valid port and the read-data gating respond to the output-enable input without waiting for a clock. A read whose address matches a write that is still in flight returns the newest bytes.

Top module: `zt_sram`

## Requirements
- R1: A read accepted at an enabled edge drives its word on `rdata` right after the second following enabled edge. Reads may be issued on every enabled edge.
- R2: A load (`burst_cont`=0) selects the block only when `ce_n_a`=0, `ce_hi`=1 and `ce_n_b`=0. Every other pattern is a deselect, which writes nothing and drives no data.
- R3: With `burst_cont`=1 the previous operation type (read, write or deselect) repeats. It uses the next burst address: the upper address bits are those of the loaded address, and the low 2 bits are (base+n) mod 4 for linear order, the default, or base XOR n when `INTERLEAVE`=1, for the n-th continuation.
- R4: While `cke_n`=1 every other synchronous input is ignored. No write occurs and the pipeline, the burst state and the output register hold their values.
- R5: On a write, byte lane i (`wdata` bits 8i+7..8i) is stored only when `lane_wr_n[i]`=0. With all lane enables high the write is aborted and memory is unchanged.
- R6: Write data is taken from `wdata` at the second enabled edge after the write's address and control are accepted.
- R7: A read completed while `oe_n`=1 is a dummy read: `rvalid`=0 and `rdata`=0. Lowering `oe_n` afterwards shows the held result without any clock edge.
- R8: A write may directly follow a read, and a read may directly follow a write, with no idle cycle between them.
- R9: A read issued on the enabled edge right after a write to the same address returns the bytes of that write that were enabled, merged with the older contents.
- R10: `rvalid` is 1 only when the output register holds a real read result and `oe_n`=0. At all other times `rdata` is 0.
- R11: After a synchronous reset the pipeline holds deselects, `rvalid`=0 and `rdata`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, low active; high suspends the block |
| ce_n_a | input | 1 | Chip enable, low active |
| ce_hi | input | 1 | Chip enable, high active |
| ce_n_b | input | 1 | Chip enable, low active |
| burst_cont | input | 1 | 0 loads a new access, 1 continues the burst |
| wr_n | input | 1 | 0 write, 1 read (sampled on load) |
| lane_wr_n | input | LANES | Per-lane write enables, low active |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Output enable, low active, not clocked |
| wdata | input | LANES*LANE_W | Late write data |
| rdata | output | LANES*LANE_W | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid on the bus |

## Verification
Several rules are checked on every clock: deselect decoding, keeping the operation type and the upper address across continues, the linear low-bit step, the freeze under suspend, the read latency, and that a valid result can only come from a read. Whether the returned data is the right data can only be shown by the bench scenarios. This covers byte merging, write aborts, forwarding from an in-flight write, data timing after a suspend, and the dummy-read behaviour of the output enable. The bench keeps its own memory image and applies writes in issue order to produce the expected words.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_RD    = 2'd1,
    OP_WR    = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int BURST_W    = 2,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              sel,
  input  logic              cont,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr_in,
  output op_e               op_nx,
  output logic [ADDR_W-1:0] addr_nx
);
  op_e                last_op;
  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] cnt;
  logic [BURST_W-1:0] cnt_nx;
  logic [BURST_W-1:0] low;

  assign cnt_nx = cnt + BURST_W'(1);

  generate
    if (INTERLEAVE) begin : g_ilv
      assign low = base[BURST_W-1:0] ^ cnt_nx;
    end else begin : g_lin
      assign low = base[BURST_W-1:0] + cnt_nx;
    end
  endgenerate

  // Decode of the access presented at this edge
  always_comb begin
    if (cont) begin
      op_nx   = last_op;
      addr_nx = {base[ADDR_W-1:BURST_W], low};
    end else if (sel) begin
      op_nx   = wr_n ? OP_RD : OP_WR;
      addr_nx = addr_in;
    end else begin
      op_nx   = OP_DESEL;
      addr_nx = addr_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_op <= OP_DESEL;
      base    <= '0;
      cnt     <= '0;
    end else if (en) begin
      last_op <= op_nx;
      if (cont) begin
        cnt <= cnt_nx;
      end else begin
        base <= addr_in;
        cnt  <= '0;
      end
    end
  end
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    en,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  // One simple dual-port, read-first memory per byte lane
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we[l]) mem[waddr] <= wdata[l*LANE_W +: LANE_W];
        q <= mem[raddr];
      end
    end
    assign rdata[l*LANE_W +: LANE_W] = q;
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int LANES      = 4,
  parameter int LANE_W     = 8,
  parameter int BURST_W    = 2,
  parameter bit INTERLEAVE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke_n,
  input  logic                    ce_n_a,
  input  logic                    ce_hi,
  input  logic                    ce_n_b,
  input  logic                    burst_cont,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        lane_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic              en;
  logic              sel;
  op_e               op_nx;
  logic [ADDR_W-1:0] addr_nx;

  op_e               a_op, b_op;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic [LANES-1:0]  a_be, b_be;

  logic [LANES-1:0]  ram_we;
  logic [DATA_W-1:0] ram_q;
  logic [LANES-1:0]  fw_be;
  logic [DATA_W-1:0] fw_data;
  logic [DATA_W-1:0] merged;
  logic              out_rd;
  logic [DATA_W-1:0] out_data;

  assign en  = ~cke_n;
  assign sel = ~ce_n_a & ce_hi & ~ce_n_b;

  zt_sram_ctrl #(
    .ADDR_W(ADDR_W), .BURST_W(BURST_W), .INTERLEAVE(INTERLEAVE)
  ) i_ctrl (
    .clk(clk), .rst(rst), .en(en), .sel(sel), .cont(burst_cont),
    .wr_n(wr_n), .addr_in(addr), .op_nx(op_nx), .addr_nx(addr_nx)
  );

  // Two-stage command pipeline; the write data meets its command in stage B
  always_ff @(posedge clk) begin
    if (rst) begin
      a_op <= OP_DESEL; b_op <= OP_DESEL;
      a_addr <= '0; b_addr <= '0;
      a_be <= '0; b_be <= '0;
    end else if (en) begin
      a_op <= op_nx; a_addr <= addr_nx; a_be <= ~lane_wr_n;
      b_op <= a_op;  b_addr <= a_addr;  b_be <= a_be;
    end
  end

  assign ram_we = (b_op == OP_WR) ? b_be : '0;

  zt_sram_array #(
    .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)
  ) i_array (
    .clk(clk), .en(en), .we(ram_we), .waddr(b_addr), .wdata(wdata),
    .raddr(a_addr), .rdata(ram_q)
  );

  // A write committing on the same edge the array is read is not seen by
  // the read-first array: capture its bytes for merging
  always_ff @(posedge clk) begin
    if (rst) begin
      fw_be   <= '0;
      fw_data <= '0;
    end else if (en) begin
      fw_be   <= (b_op == OP_WR && b_addr == a_addr) ? b_be : '0;
      fw_data <= wdata;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_merge
    assign merged[l*LANE_W +: LANE_W] =
      fw_be[l] ? fw_data[l*LANE_W +: LANE_W] : ram_q[l*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_rd   <= 1'b0;
      out_data <= '0;
    end else if (en) begin
      out_rd   <= (b_op == OP_RD);
      out_data <= merged;
    end
  end

  assign rvalid = out_rd & ~oe_n;
  assign rdata  = rvalid ? out_data : '0;

  // ---------------- assertions ----------------
  p_desel_decode_r2: assert property (@(posedge clk) disable iff (rst)
    en && !burst_cont && !sel |=> a_op == OP_DESEL);

  p_cont_type_r3: assert property (@(posedge clk) disable iff (rst)
    en && burst_cont |=> a_op == $past(a_op));

  p_cont_upper_r3: assert property (@(posedge clk) disable iff (rst)
    en && burst_cont |=> a_addr[ADDR_W-1:BURST_W] == $past(a_addr[ADDR_W-1:BURST_W]));

  if (!INTERLEAVE) begin : g_chk_lin
    p_cont_step_r3: assert property (@(posedge clk) disable iff (rst)
      en && burst_cont |=> a_addr[BURST_W-1:0] == $past(a_addr[BURST_W-1:0]) + BURST_W'(1));
  end

  p_freeze_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(a_op) && $stable(b_op) && $stable(a_addr) && $stable(out_rd));

  p_freeze_out_r4: assert property (@(posedge clk) disable iff (rst)
    !en |=> (oe_n != $past(oe_n)) || ($stable(rdata) && $stable(rvalid)));

  p_latency_r1: assert property (@(posedge clk) disable iff (rst)
    en && b_op == OP_RD |=> out_rd);

  p_valid_src_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(rvalid) && !$rose(out_rd) |-> $fell(oe_n));
endmodule

// File: tb/test_zt_sram.sv
`timescale 1ns/1ps
module test_zt_sram;
  localparam int AW = 6;
  localparam int LN = 4;
  localparam int LW = 8;
  localparam int DW = LN * LW;
  localparam bit ILV = 1'b0;
  localparam bit [2:0] SEL = 3'b010;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke_n = 1'b0, ce_n_a = 1'b1, ce_hi = 1'b0, ce_n_b = 1'b1;
  logic burst_cont = 1'b0, wr_n = 1'b1, oe_n = 1'b0;
  logic [LN-1:0] lane_wr_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rvalid;

  always #2.5 clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW), .BURST_W(2), .INTERLEAVE(ILV)) i_zt_sram (
    .clk(clk), .rst(rst), .cke_n(cke_n), .ce_n_a(ce_n_a), .ce_hi(ce_hi), .ce_n_b(ce_n_b),
    .burst_cont(burst_cont), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid));

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] model [1<<AW];
  int q_kind [2];
  int q_addr [2];
  logic [LN-1:0] q_be [2];
  logic [DW-1:0] q_data [2];
  int last_kind = 0;
  int base_a = 0;
  int bcnt = 0;
  int seq = 1;

  function automatic logic [DW-1:0] hash(input int n);
    return DW'(32'h9E3779B1 * n + 32'h1234567);
  endfunction

  function automatic int burst_addr(input int b, input int n);
    if (ILV) return (b & ~3) | ((b ^ n) & 3);
    return (b & ~3) | ((b + n) & 3);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, then compare the output against the spec model
  task automatic cyc(input bit cont, input bit [2:0] ce, input bit wen, input int a,
                     input bit [LN-1:0] wrn, input bit oen, input bit ckn, input string tag);
    int kind;
    int ea;
    logic [DW-1:0] prev_d;
    logic prev_v;
    logic exp_v;
    logic [DW-1:0] exp_d;
    @(negedge clk);
    prev_d = rdata;
    prev_v = rvalid;
    burst_cont = cont; {ce_n_a, ce_hi, ce_n_b} = ce; wr_n = wen;
    addr = AW'(a); lane_wr_n = wrn; oe_n = oen; cke_n = ckn;
    if (!ckn && q_kind[1] == 2) wdata = q_data[1];
    else wdata = ~hash(seq + 77);
    @(posedge clk);
    #1;
    if (ckn) begin
      chk(rdata == prev_d && rvalid == prev_v, {tag, " R4 hold"}, {31'b0, rvalid, rdata}, {31'b0, prev_v, prev_d});
      return;
    end
    if (cont) begin
      kind = last_kind; bcnt++; ea = burst_addr(base_a, bcnt);
    end else if (ce == SEL) begin
      kind = wen ? 1 : 2; base_a = a; bcnt = 0; ea = a;
    end else begin
      kind = 0; ea = a;
    end
    last_kind = kind;
    if (q_kind[1] == 2)
      for (int l = 0; l < LN; l++)
        if (q_be[1][l]) model[q_addr[1]][l*LW +: LW] = q_data[1][l*LW +: LW];
    exp_v = (q_kind[1] == 1) && !oen;
    exp_d = exp_v ? model[q_addr[1]] : '0;
    chk(rvalid == exp_v && rdata == exp_d, tag, {31'b0, rvalid, rdata}, {31'b0, exp_v, exp_d});
    q_kind[1] = q_kind[0]; q_addr[1] = q_addr[0]; q_be[1] = q_be[0]; q_data[1] = q_data[0];
    q_kind[0] = kind; q_addr[0] = ea & ((1 << AW) - 1); q_be[0] = ~wrn; q_data[0] = hash(seq);
    seq++;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(0, 3'b110, 1, 0, '1, 0, 0, tag);
  endtask

  initial begin
    q_kind[0] = 0; q_kind[1] = 0; q_addr[0] = 0; q_addr[1] = 0;
    q_be[0] = '0; q_be[1] = '0; q_data[0] = '0; q_data[1] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(rvalid == 1'b0 && rdata == '0, "R11 reset outputs", {31'b0, rvalid, rdata}, 64'd0);
    idle(2, "R11 after reset");

    // Fill every word back to back, then read every word back to back
    for (int a = 0; a < (1 << AW); a++) cyc(0, SEL, 0, a, '0, 0, 0, "R6 fill");
    for (int a = 0; a < (1 << AW); a++) cyc(0, SEL, 1, a, '1, 0, 0, "R1 read");
    idle(2, "R1 drain");

    // All lane-enable patterns, including the all-high abort
    for (int m = 0; m < 16; m++) cyc(0, SEL, 0, m, LN'(m), 0, 0, "R5 lane write");
    for (int m = 0; m < 16; m++) cyc(0, SEL, 1, m, '1, 0, 0, "R5 lane read");
    idle(2, "R5 drain");

    // Turnarounds and forwarding from in-flight writes
    for (int a = 20; a < 28; a++) begin
      cyc(0, SEL, 0, a, '0, 0, 0, "R8 write");
      cyc(0, SEL, 1, a, '1, 0, 0, "R9 read after write");
      cyc(0, SEL, 1, a + 1, '1, 0, 0, "R8 read");
      cyc(0, SEL, 0, a + 1, 4'b1010, 0, 0, "R8 write after read");
      cyc(0, SEL, 1, a + 1, '1, 0, 0, "R9 partial forward");
    end
    cyc(0, SEL, 0, 30, 4'b0110, 0, 0, "R9 write");
    cyc(0, 3'b110, 1, 0, '1, 0, 0, "R9 gap");
    cyc(0, SEL, 1, 30, '1, 0, 0, "R9 read two later");
    idle(2, "R9 drain");

    // Bursts: read from each start offset, then write bursts with varied lanes
    for (int s = 0; s < 4; s++) begin
      cyc(0, SEL, 1, 32 + s, '1, 0, 0, "R3 burst read load");
      for (int j = 0; j < 3; j++) cyc(1, 3'b111, 0, 5, '0, 0, 0, "R3 burst read cont");
    end
    for (int s = 0; s < 4; s++) begin
      cyc(0, SEL, 0, 40 + s, '0, 0, 0, "R3 burst write load");
      for (int j = 0; j < 3; j++) cyc(1, 3'b000, 1, 9, LN'(j * 5), 0, 0, "R3 burst write cont");
    end
    for (int a = 40; a < 44; a++) cyc(0, SEL, 1, a, '1, 0, 0, "R3 burst write check");
    idle(2, "R3 drain");

    // Every chip-enable pattern with a write, then read back
    for (int c = 0; c < 8; c++) cyc(0, 3'(c), 0, 48 + c, '0, 0, 0, "R2 enable pattern");
    cyc(0, 3'b110, 0, 56, '0, 0, 0, "R2 deselect");
    for (int j = 0; j < 3; j++) cyc(1, SEL, 0, 57, '0, 0, 0, "R2 continued deselect");
    for (int a = 48; a < 60; a++) cyc(0, SEL, 1, a, '1, 0, 0, "R2 read back");
    idle(2, "R10 idle");

    // Suspend in the middle of writes and reads, with garbage on the inputs
    cyc(0, SEL, 0, 60, '0, 0, 0, "R4 write");
    for (int j = 0; j < 3; j++) cyc(j[0], SEL, 0, 61, '0, 0, 1, "R4 suspend");
    cyc(0, SEL, 1, 60, '1, 0, 0, "R4 read");
    cyc(0, SEL, 1, 61, '1, 0, 0, "R4 read");
    cyc(0, SEL, 0, 62, '0, 0, 1, "R4 suspend");
    cyc(0, 3'b110, 1, 0, '1, 0, 0, "R4 resume");
    for (int j = 0; j < 2; j++) cyc(1, SEL, 0, 63, '0, 0, 1, "R4 suspend with data out");
    idle(3, "R4 drain");

    // Dummy read, then reveal the held word with the output enable alone
    cyc(0, SEL, 1, 33, '1, 0, 0, "R7 read");
    cyc(0, 3'b110, 1, 0, '1, 0, 0, "R7 gap");
    cyc(0, 3'b110, 1, 0, '1, 1, 0, "R7 dummy read");
    #0.5;
    oe_n = 1'b0;
    #0.5;
    chk(rvalid == 1'b1 && rdata == model[33], "R7 enable without clock",
        {31'b0, rvalid, rdata}, {31'b0, 1'b1, model[33]});
    idle(3, "R10 final idle");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule